// File: doc/BRIEF.md
# Dual-Side Mailbox with Interrupts

This block is a small register file shared by two bus agents: a host on one side and an embedded processor core on the other. Each side has its own register port with an address, a read strobe, a write strobe, write data and combinational read data. Through these ports both sides see the same set of registers: two 16-bit incoming mailboxes (host to core), two 16-bit outgoing mailboxes (core to host), a status register and a control register.

Every mailbox has a valid flag. The block watches the accesses for four message events and records them as interrupt-pending bits. The four events are: the host fills an inbox, the core drains an inbox, the core fills an outbox, and the host acknowledges an outbox. Each pending bit has an enable, and the pending bits are grouped by who must be told. The host is told about inbox drains and outbox fills. Two core interrupt targets are each told about inbox fills and outbox acknowledges. A host read never has a side effect. For that reason the host acknowledges an outbox by writing a one to that outbox's valid bit in the status register, and that write is what raises the core-side event. Pending bits are cleared by writing ones to them.

Top module: `dual_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every mailbox, valid flag, pending bit and enable is zero, so every register reads zero and all three interrupt outputs are low.
- R2: Addresses 0 and 1 select inbox 0 and 1, addresses 2 and 3 select outbox 0 and 1, address 4 the status register and address 5 the control register. A mailbox written from either port reads back the written word from both ports. Reads from addresses 6 and 7 return zero, and writes to them change nothing. Read data is zero when the read strobe is low.
- R3: The status register holds pending bits in 0 to 11, inbox valid flags in 12 (inbox 0) and 13 (inbox 1), and outbox valid flags in 14 (outbox 0) and 15 (outbox 1). A write to inbox i from either port sets status bit 12+i. A host write to inbox i also sets pending bits 4+i and 8+i, each if enabled.
- R4: A core read of inbox i while its valid flag is set clears that flag and sets pending bit i, if enabled. A core read of an empty inbox sets nothing.
- R5: A core write to outbox j sets status bit 14+j and pending bit 2+j, if enabled. A host write to an outbox changes only its data.
- R6: A host write to the status register with bit 14+j at one, while outbox j is valid, clears that valid flag and sets pending bits 6+j and 10+j, each if enabled. With the flag already clear, the write raises nothing. Core writes to bits 12 to 15 have no effect.
- R7: A host read of any register changes no flag, pending bit, enable or mailbox.
- R8: A write to the status register from either port clears every pending bit (0 to 11) whose data bit is one, and leaves bits with data zero unchanged.
- R9: When an enabled event and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: When both ports write the same mailbox or the control register in the same cycle, the host data is stored.
- R11: The host interrupt is high exactly when any of pending bits 0 to 3 is set. Core interrupt 1 is high when any of bits 4 to 7 is set, and core interrupt 2 when any of bits 8 to 11 is set.
- R12: Control bits 0 to 11 are read/write enables for the pending bits in the same positions, and control bits 12 to 15 read zero. An event whose enable is zero at the time of the event leaves its pending bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 3 | Host register address |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, combinational |
| cor_addr | input | 3 | Core register address |
| cor_rd | input | 1 | Core read strobe |
| cor_wr | input | 1 | Core write strobe |
| cor_wdata | input | 16 | Core write data |
| cor_rdata | output | 16 | Core read data, combinational |
| host_irq | output | 1 | Host interrupt request |
| core1_irq | output | 1 | Core interrupt request, target 1 |
| core2_irq | output | 1 | Core interrupt request, target 2 |

## Verification
Two functions can land in the same cycle: an event that sets a pending bit, and a write-one that clears the same bit. An example is a core write to outbox 1 in the same cycle as a host status write of 0x0008. The directed part of the bench forces this coincidence, together with simultaneous writes from both ports to one mailbox and to the control register. The random part lets such collisions happen freely between the two ports. In every case the next status read is judged against a bench model in which the set takes effect after the clear and the host data wins over the core data.

// File: rtl/mbx_pkg.sv
// Package mbx_pkg
// Shared constants for the dual-side mailbox. The status register is a set
// of groups, each one bit per mailbox index, stacked from bit 0 upward.
// Assumes the mailbox count per direction is the group width.
package mbx_pkg;
    // pending groups, in status bit order
    localparam int G_HOST_IN   = 0;  // core drained an inbox
    localparam int G_HOST_OUT  = 1;  // core filled an outbox
    localparam int G_C1_IN     = 2;  // host filled an inbox, core target 1
    localparam int G_C1_OUT    = 3;  // host acknowledged an outbox, target 1
    localparam int G_C2_IN     = 4;  // host filled an inbox, core target 2
    localparam int G_C2_OUT    = 5;  // host acknowledged an outbox, target 2
    // flag groups above the pending bits
    localparam int G_IN_VALID  = 6;
    localparam int G_OUT_VALID = 7;

    localparam int N_PEND_GROUPS = 6;
    localparam int N_STAT_GROUPS = 8;

    // access kinds used by the address decoders
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/mbx_decode.sv
// Module mbx_decode
// Turns one register port's address and write strobe into one-hot write
// selects: one per mailbox, one for status, one for control.
// Assumes mailboxes sit at addresses 0..2*NBOX-1, status right after them
// and control after that; other addresses decode to nothing.
module mbx_decode #(
    parameter int NBOX   = 2,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [2*NBOX-1:0] box_wr,
    output logic              stat_wr,
    output logic              ctrl_wr
);
    localparam int NB2 = 2 * NBOX;

    // decode the write target of this port
    always_comb begin
        for (int k = 0; k < NB2; k++) begin
            box_wr[k] = wr && (addr == ADDR_W'(k));
        end
        stat_wr = wr && (addr == ADDR_W'(NB2));
        ctrl_wr = wr && (addr == ADDR_W'(NB2 + 1));
    end
endmodule

// File: rtl/mbx_store.sv
// Module mbx_store
// Data words of all mailboxes: the inboxes first, then the outboxes.
// Either port may write any box; the host write wins a same-cycle clash.
// Assumes synchronous active-low reset.
module mbx_store #(
    parameter int NBOX   = 2,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NBOX-1:0]   h_wr,
    input  logic [2*NBOX-1:0]   c_wr,
    input  logic [DATA_W-1:0]   h_wdata,
    input  logic [DATA_W-1:0]   c_wdata,
    output logic [DATA_W-1:0]   box_q [2*NBOX]
);
    localparam int NB2 = 2 * NBOX;

    for (genvar g = 0; g < NB2; g++) begin : g_box
        // hold one mailbox word, host data first (R10)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                box_q[g] <= '0;
            end else if (h_wr[g]) begin
                box_q[g] <= h_wdata;
            end else if (c_wr[g]) begin
                box_q[g] <= c_wdata;
            end
        end
    end
endmodule

// File: rtl/mbx_flags.sv
// Module mbx_flags
// Valid flags of every mailbox and detection of the four message events.
// Inbox flags: set by any write, cleared by a core read of a full inbox.
// Outbox flags: set by a core write, cleared only by a host acknowledge
// (a status write with the flag's bit at one while the flag is set).
// A set in the same cycle as a clear leaves the flag set.
// Assumes host reads never reach this module (no read side effects).
module mbx_flags #(
    parameter int NBOX = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBOX-1:0]          h_in_wr,
    input  logic [2*NBOX-1:0]        c_box_wr,
    input  logic [NBOX-1:0]          c_in_rd,
    input  logic                     h_stat_wr,
    input  logic [NBOX-1:0]          h_ack_bits,
    output logic [NBOX-1:0]          in_valid,
    output logic [NBOX-1:0]          out_valid,
    output logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0] ev
);
    import mbx_pkg::*;

    localparam int NP = N_PEND_GROUPS * NBOX;

    logic [NBOX-1:0] drain;
    logic [NBOX-1:0] ack;
    logic [NBOX-1:0] c_in_wr;
    logic [NBOX-1:0] c_out_wr;
    logic [NBOX-1:0] in_valid_d;
    logic [NBOX-1:0] out_valid_d;

    // split the core write selects into inbox and outbox halves
    always_comb begin
        c_in_wr  = c_box_wr[NBOX-1:0];
        c_out_wr = c_box_wr[2*NBOX-1:NBOX];
    end

    // qualify drains and acknowledges by the current flags
    always_comb begin
        drain = c_in_rd & in_valid;
        ack   = {NBOX{h_stat_wr}} & h_ack_bits & out_valid;
    end

    // place each event into its pending group (R3, R4, R5, R6)
    always_comb begin
        ev = '0;
        ev[G_HOST_IN*NBOX  +: NBOX] = drain;
        ev[G_HOST_OUT*NBOX +: NBOX] = c_out_wr;
        ev[G_C1_IN*NBOX    +: NBOX] = h_in_wr;
        ev[G_C2_IN*NBOX    +: NBOX] = h_in_wr;
        ev[G_C1_OUT*NBOX   +: NBOX] = ack;
        ev[G_C2_OUT*NBOX   +: NBOX] = ack;
    end

    // next flag values, set after clear
    always_comb begin
        in_valid_d  = (in_valid & ~drain) | h_in_wr | c_in_wr;
        out_valid_d = (out_valid & ~ack) | c_out_wr;
    end

    // flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_valid  <= '0;
            out_valid <= '0;
        end else begin
            in_valid  <= in_valid_d;
            out_valid <= out_valid_d;
        end
    end

    // keep NP visible as the width of ev for readers
    localparam int EV_W = NP;
endmodule

// File: rtl/mbx_pending.sv
// Module mbx_pending
// Interrupt-pending bits with write-one-to-clear, their enables, and the
// three interrupt outputs. An enabled event sets its bit; a set in the same
// cycle as a clear wins (R9). Enables used are those before this cycle's
// control write. Host control data wins a same-cycle clash (R10).
module mbx_pending #(
    parameter int NBOX = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  ev,
    input  logic                                    h_stat_wr,
    input  logic                                    c_stat_wr,
    input  logic                                    h_ctrl_wr,
    input  logic                                    c_ctrl_wr,
    input  logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  h_bits,
    input  logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  c_bits,
    output logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  pend_q,
    output logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  en_q,
    output logic                                    host_irq,
    output logic                                    core1_irq,
    output logic                                    core2_irq
);
    import mbx_pkg::*;

    localparam int NP = N_PEND_GROUPS * NBOX;

    logic [NP-1:0] clr;
    logic [NP-1:0] pend_d;

    // merge write-one clears from both ports (R8)
    always_comb begin
        clr = (h_stat_wr ? h_bits : '0) | (c_stat_wr ? c_bits : '0);
    end

    // next pending value, event set after clear (R9, R12)
    always_comb begin
        pend_d = (pend_q & ~clr) | (ev & en_q);
    end

    // pending register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // enable register, host first (R10, R12)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (h_ctrl_wr) begin
            en_q <= h_bits;
        end else if (c_ctrl_wr) begin
            en_q <= c_bits;
        end
    end

    // interrupt lines as group ORs (R11)
    always_comb begin
        host_irq  = (|pend_q[G_HOST_IN*NBOX +: NBOX]) | (|pend_q[G_HOST_OUT*NBOX +: NBOX]);
        core1_irq = (|pend_q[G_C1_IN*NBOX   +: NBOX]) | (|pend_q[G_C1_OUT*NBOX   +: NBOX]);
        core2_irq = (|pend_q[G_C2_IN*NBOX   +: NBOX]) | (|pend_q[G_C2_OUT*NBOX   +: NBOX]);
    end
endmodule

// File: rtl/dual_mailbox.sv
// Module dual_mailbox
// Top of the dual-side mailbox: two register ports (host, core), mailbox
// storage, valid flags, event detection, pending bits and interrupts.
// Read data is combinational from the current state and zero when the
// read strobe is low. Host reads have no effect on any state (R7).
// Assumes DATA_W >= 8*NBOX and 2*NBOX+2 <= 2**ADDR_W.
module dual_mailbox #(
    parameter int NBOX   = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic [ADDR_W-1:0] cor_addr,
    input  logic              cor_rd,
    input  logic              cor_wr,
    input  logic [DATA_W-1:0] cor_wdata,
    output logic [DATA_W-1:0] cor_rdata,
    output logic              host_irq,
    output logic              core1_irq,
    output logic              core2_irq
);
    import mbx_pkg::*;

    localparam int NB2    = 2 * NBOX;
    localparam int NP     = N_PEND_GROUPS * NBOX;
    localparam int STAT_W = N_STAT_GROUPS * NBOX;
    localparam int ACK_LO = G_OUT_VALID * NBOX;

    logic [NB2-1:0]    h_box_wr;
    logic [NB2-1:0]    c_box_wr;
    logic              h_stat_wr;
    logic              c_stat_wr;
    logic              h_ctrl_wr;
    logic              c_ctrl_wr;
    logic [NBOX-1:0]   c_in_rd;
    logic [DATA_W-1:0] box_q [NB2];
    logic [NBOX-1:0]   in_valid;
    logic [NBOX-1:0]   out_valid;
    logic [NP-1:0]     ev;
    logic [NP-1:0]     pend_q;
    logic [NP-1:0]     en_q;
    logic [STAT_W-1:0] stat_vec;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ctrl_word;

    mbx_decode #(.NBOX(NBOX), .ADDR_W(ADDR_W)) u_hdec (
        .addr    (hst_addr),
        .wr      (hst_wr),
        .box_wr  (h_box_wr),
        .stat_wr (h_stat_wr),
        .ctrl_wr (h_ctrl_wr)
    );

    mbx_decode #(.NBOX(NBOX), .ADDR_W(ADDR_W)) u_cdec (
        .addr    (cor_addr),
        .wr      (cor_wr),
        .box_wr  (c_box_wr),
        .stat_wr (c_stat_wr),
        .ctrl_wr (c_ctrl_wr)
    );

    // core reads of inboxes are the only reads with an effect (R4)
    always_comb begin
        for (int i = 0; i < NBOX; i++) begin
            c_in_rd[i] = cor_rd && (cor_addr == ADDR_W'(i));
        end
    end

    mbx_store #(.NBOX(NBOX), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_wr    (h_box_wr),
        .c_wr    (c_box_wr),
        .h_wdata (hst_wdata),
        .c_wdata (cor_wdata),
        .box_q   (box_q)
    );

    mbx_flags #(.NBOX(NBOX)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_in_wr    (h_box_wr[NBOX-1:0]),
        .c_box_wr   (c_box_wr),
        .c_in_rd    (c_in_rd),
        .h_stat_wr  (h_stat_wr),
        .h_ack_bits (hst_wdata[ACK_LO +: NBOX]),
        .in_valid   (in_valid),
        .out_valid  (out_valid),
        .ev         (ev)
    );

    mbx_pending #(.NBOX(NBOX)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .h_stat_wr (h_stat_wr),
        .c_stat_wr (c_stat_wr),
        .h_ctrl_wr (h_ctrl_wr),
        .c_ctrl_wr (c_ctrl_wr),
        .h_bits    (hst_wdata[NP-1:0]),
        .c_bits    (cor_wdata[NP-1:0]),
        .pend_q    (pend_q),
        .en_q      (en_q),
        .host_irq  (host_irq),
        .core1_irq (core1_irq),
        .core2_irq (core2_irq)
    );

    // assemble the status and control words (R3, R12)
    always_comb begin
        stat_vec  = {out_valid, in_valid, pend_q};
        stat_word = DATA_W'(stat_vec);
        ctrl_word = DATA_W'(en_q);
    end

    // pick the word one port addresses (R2)
    function automatic logic [DATA_W-1:0] pick_word(
        input logic              rd,
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] bx [NB2],
        input logic [DATA_W-1:0] sw,
        input logic [DATA_W-1:0] cw
    );
        logic [DATA_W-1:0] w;
        w = '0;
        if (rd) begin
            for (int k = 0; k < NB2; k++) begin
                if (a == ADDR_W'(k)) w = bx[k];
            end
            if (a == ADDR_W'(NB2))     w = sw;
            if (a == ADDR_W'(NB2 + 1)) w = cw;
        end
        return w;
    endfunction

    // host read data
    always_comb begin
        hst_rdata = pick_word(hst_rd, hst_addr, box_q, stat_word, ctrl_word);
    end

    // core read data
    always_comb begin
        cor_rdata = pick_word(cor_rd, cor_addr, box_q, stat_word, ctrl_word);
    end
endmodule

// File: rtl/mbx_checker.sv
// Module mbx_checker
// Clocked properties of the dual-side mailbox, bound to the top module.
module mbx_checker #(
    parameter int NBOX = 2
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    hst_rd,
    input logic                                    hst_wr,
    input logic                                    cor_rd,
    input logic                                    cor_wr,
    input logic [NBOX-1:0]                         h_in_wr,
    input logic [NBOX-1:0]                         c_in_rd,
    input logic [NBOX-1:0]                         c_out_wr,
    input logic                                    h_stat_wr,
    input logic [NBOX-1:0]                         h_ack_bits,
    input logic [NBOX-1:0]                         in_valid,
    input logic [NBOX-1:0]                         out_valid,
    input logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  pend,
    input logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  en,
    input logic [mbx_pkg::N_PEND_GROUPS*NBOX-1:0]  ev,
    input logic                                    host_irq,
    input logic                                    core1_irq,
    input logic                                    core2_irq
);
    import mbx_pkg::*;

    localparam int NP = N_PEND_GROUPS * NBOX;

    for (genvar i = 0; i < NBOX; i++) begin : g_box
        // R3: a host inbox write leaves the inbox full
        a_r3_inbox_fills: assert property (@(posedge clk) disable iff (!rst_n)
            h_in_wr[i] |=> in_valid[i]);

        // R4: host-side drain bit rises only after a core read of a full inbox
        a_r4_drain_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[G_HOST_IN*NBOX + i]) |-> $past(c_in_rd[i] && in_valid[i]));

        // R5: a core outbox write leaves the outbox full
        a_r5_outbox_fills: assert property (@(posedge clk) disable iff (!rst_n)
            c_out_wr[i] |=> out_valid[i]);

        // R6: an outbox empties only on a host acknowledge write
        a_r6_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(out_valid[i]) |-> $past(h_stat_wr && h_ack_bits[i]));
    end

    for (genvar k = 0; k < NP; k++) begin : g_bit
        // R9: an enabled event always lands, even against a clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[k] && en[k]) |=> pend[k]);
    end

    // R7: a lone host read leaves flags, pending bits and enables alone
    a_r7_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && !hst_wr && !cor_rd && !cor_wr)
        |=> ($stable(pend) && $stable(en) && $stable(in_valid) && $stable(out_valid)));

    // R11: no pending bit, no interrupt
    a_r11_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !(host_irq || core1_irq || core2_irq));
endmodule

bind dual_mailbox mbx_checker #(.NBOX(NBOX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_rd     (hst_rd),
    .hst_wr     (hst_wr),
    .cor_rd     (cor_rd),
    .cor_wr     (cor_wr),
    .h_in_wr    (h_box_wr[NBOX-1:0]),
    .c_in_rd    (c_in_rd),
    .c_out_wr   (c_box_wr[2*NBOX-1:NBOX]),
    .h_stat_wr  (h_stat_wr),
    .h_ack_bits (hst_wdata[mbx_pkg::G_OUT_VALID*NBOX +: NBOX]),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .pend       (pend_q),
    .en         (en_q),
    .ev         (ev),
    .host_irq   (host_irq),
    .core1_irq  (core1_irq),
    .core2_irq  (core2_irq)
);

// File: tb/dual_mailbox_tb.sv
// Bench for dual_mailbox: directed corner cases, then seeded random traffic
// on both ports, all judged against a requirement-level model.
module dual_mailbox_tb;
    localparam int OP_NONE = 0;
    localparam int OP_RD   = 1;
    localparam int OP_WR   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic        hst_rd = 1'b0;
    logic        hst_wr = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic [2:0]  cor_addr = '0;
    logic        cor_rd = 1'b0;
    logic        cor_wr = 1'b0;
    logic [15:0] cor_wdata = '0;
    logic [15:0] cor_rdata;
    logic        host_irq;
    logic        core1_irq;
    logic        core2_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    logic [15:0] m_box [4];
    logic [11:0] m_pend;
    logic [11:0] m_en;
    logic [1:0]  m_inv;
    logic [1:0]  m_outv;

    always #10 clk = ~clk;

    dual_mailbox u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_addr  (hst_addr),
        .hst_rd    (hst_rd),
        .hst_wr    (hst_wr),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .cor_addr  (cor_addr),
        .cor_rd    (cor_rd),
        .cor_wr    (cor_wr),
        .cor_wdata (cor_wdata),
        .cor_rdata (cor_rdata),
        .host_irq  (host_irq),
        .core1_irq (core1_irq),
        .core2_irq (core2_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected read word from the model (R2, R3, R12)
    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2, 3'd3: return m_box[a[1:0]];
            3'd4: return {m_outv, m_inv, m_pend};
            3'd5: return {4'b0, m_en};
            default: return 16'h0000;
        endcase
    endfunction

    // advance the model over one cycle of accesses
    task automatic model_step(input int h_op, input logic [2:0] h_a, input logic [15:0] h_d,
                              input int c_op, input logic [2:0] c_a, input logic [15:0] c_d);
        logic [11:0] evs;
        logic [11:0] clr;
        logic [1:0]  n_inv;
        logic [1:0]  n_outv;
        bit hw, cw, cr;
        hw = (h_op == OP_WR);
        cw = (c_op == OP_WR);
        cr = (c_op == OP_RD);
        evs = '0;
        n_inv  = m_inv;
        n_outv = m_outv;
        for (int i = 0; i < 2; i++) begin
            if (cr && c_a == 3'(i) && m_inv[i]) begin
                evs[i] = 1'b1;
                n_inv[i] = 1'b0;
            end
            if (hw && h_a == 3'(i)) begin
                evs[4+i] = 1'b1;
                evs[8+i] = 1'b1;
            end
            if ((hw && h_a == 3'(i)) || (cw && c_a == 3'(i))) n_inv[i] = 1'b1;
            if (hw && h_a == 3'd4 && h_d[14+i] && m_outv[i]) begin
                evs[6+i]  = 1'b1;
                evs[10+i] = 1'b1;
                n_outv[i] = 1'b0;
            end
            if (cw && c_a == 3'(2+i)) begin
                evs[2+i] = 1'b1;
                n_outv[i] = 1'b1;
            end
        end
        clr = ((hw && h_a == 3'd4) ? h_d[11:0] : 12'h000) |
              ((cw && c_a == 3'd4) ? c_d[11:0] : 12'h000);
        for (int k = 0; k < 4; k++) begin
            if (hw && h_a == 3'(k)) m_box[k] = h_d;
            else if (cw && c_a == 3'(k)) m_box[k] = c_d;
        end
        m_pend = (m_pend & ~clr) | (evs & m_en);
        if (hw && h_a == 3'd5) m_en = h_d[11:0];
        else if (cw && c_a == 3'd5) m_en = c_d[11:0];
        m_inv  = n_inv;
        m_outv = n_outv;
    endtask

    // one bus cycle on both ports, with read and interrupt checks
    task automatic step(input string tag,
                        input int h_op, input logic [2:0] h_a, input logic [15:0] h_d,
                        input int c_op, input logic [2:0] c_a, input logic [15:0] c_d);
        @(negedge clk);
        hst_rd = (h_op == OP_RD);
        hst_wr = (h_op == OP_WR);
        hst_addr = h_a;
        hst_wdata = h_d;
        cor_rd = (c_op == OP_RD);
        cor_wr = (c_op == OP_WR);
        cor_addr = c_a;
        cor_wdata = c_d;
        #2;
        if (h_op == OP_RD) check({tag, " host read"}, hst_rdata, exp_rd(h_a));
        if (c_op == OP_RD) check({tag, " core read"}, cor_rdata, exp_rd(c_a));
        check("R11 irq lines", {13'b0, host_irq, core1_irq, core2_irq},
              {13'b0, |m_pend[3:0], |m_pend[7:4], |m_pend[11:8]});
        model_step(h_op, h_a, h_d, c_op, c_a, c_d);
        @(posedge clk);
    endtask

    task automatic hread(input string tag, input logic [2:0] a);
        step(tag, OP_RD, a, 16'h0, OP_NONE, 3'd0, 16'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rdummy;
        rdummy = $urandom(32'h5eed_0c1a);
        for (int k = 0; k < 4; k++) m_box[k] = '0;
        m_pend = '0; m_en = '0; m_inv = '0; m_outv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero out of reset
        for (int a = 0; a < 6; a++) begin
            step("R1 reset", OP_RD, 3'(a), 16'h0, OP_RD, 3'(a), 16'h0);
        end

        // R12: enables read back in bits 0..11 only
        step("R12 ctrl write", OP_WR, 3'd5, 16'hFFFF, OP_NONE, 3'd0, 16'h0);
        step("R12 ctrl readback", OP_RD, 3'd5, 16'h0, OP_RD, 3'd5, 16'h0);

        // R3: host fills inbox 0, expect bits 4, 8, 12
        step("R2 host write", OP_WR, 3'd0, 16'h1234, OP_NONE, 3'd0, 16'h0);
        hread("R3 status after fill", 3'd4);

        // R4: core drains inbox 0, expect bit 0 set and bit 12 cleared
        step("R2 R4 core drain", OP_NONE, 3'd0, 16'h0, OP_RD, 3'd0, 16'h0);
        hread("R4 status after drain", 3'd4);

        // R8: clear bit 0 by host, then a zero write by core does nothing
        step("R8 clear", OP_WR, 3'd4, 16'h0001, OP_NONE, 3'd0, 16'h0);
        step("R4 empty read", OP_NONE, 3'd0, 16'h0, OP_RD, 3'd0, 16'h0);
        hread("R4 no event on empty", 3'd4);
        step("R8 zero write", OP_NONE, 3'd0, 16'h0, OP_WR, 3'd4, 16'h0000);
        hread("R8 unchanged", 3'd4);
        step("R8 core clear", OP_NONE, 3'd0, 16'h0, OP_WR, 3'd4, 16'h0110);
        hread("R8 cleared", 3'd4);

        // R5: core fills outbox 0, expect bits 2 and 14
        step("R5 core fill", OP_NONE, 3'd0, 16'h0, OP_WR, 3'd2, 16'hCAFE);
        hread("R5 status after fill", 3'd4);

        // R7: repeated host reads change nothing
        hread("R7 host read", 3'd2);
        hread("R7 host read", 3'd2);
        hread("R7 host read", 3'd0);
        hread("R7 status unchanged", 3'd4);

        // R6: acknowledge outbox 0, expect bits 6 and 10, valid gone
        step("R6 ack", OP_WR, 3'd4, 16'h4004, OP_NONE, 3'd0, 16'h0);
        hread("R6 status after ack", 3'd4);
        step("R6 ack when empty", OP_WR, 3'd4, 16'h4440, OP_NONE, 3'd0, 16'h0);
        hread("R6 no event when empty", 3'd4);
        step("R6 core write valid bit", OP_NONE, 3'd0, 16'h0, OP_WR, 3'd4, 16'hF000);
        hread("R6 core ignored", 3'd4);

        // R9: fill outbox 1 while host clears bit 3
        step("R9 collide", OP_WR, 3'd4, 16'h0008, OP_WR, 3'd3, 16'hAAAA);
        hread("R9 set wins", 3'd4);

        // R10: both ports write inbox 0 and then control together
        step("R10 box clash", OP_WR, 3'd0, 16'h1111, OP_WR, 3'd0, 16'h2222);
        step("R10 box readback", OP_RD, 3'd0, 16'h0, OP_RD, 3'd0, 16'h0);
        step("R10 ctrl clash", OP_WR, 3'd5, 16'h000F, OP_WR, 3'd5, 16'h0FF0);
        hread("R10 ctrl readback", 3'd5);

        // R12: disabled events leave pending clear
        step("R12 disable", OP_WR, 3'd5, 16'h0000, OP_WR, 3'd4, 16'h0FFF);
        step("R12 fill", OP_WR, 3'd1, 16'h5555, OP_NONE, 3'd0, 16'h0);
        hread("R12 no pending", 3'd4);

        // R2: unmapped addresses
        step("R2 unmapped write", OP_WR, 3'd6, 16'hFFFF, OP_WR, 3'd7, 16'hFFFF);
        step("R2 unmapped read", OP_RD, 3'd7, 16'h0, OP_RD, 3'd6, 16'h0);

        // enable everything, then random traffic on both ports
        step("R12 enable all", OP_WR, 3'd5, 16'h0FFF, OP_NONE, 3'd0, 16'h0);
        for (int n = 0; n < 6000; n++) begin
            int ho, co;
            logic [2:0]  ha, ca;
            logic [15:0] hd, cd;
            ho = int'($urandom_range(0, 2));
            co = int'($urandom_range(0, 2));
            ha = 3'($urandom_range(0, 7));
            ca = 3'($urandom_range(0, 7));
            hd = 16'($urandom);
            cd = 16'($urandom);
            if (ha == 3'd5 && ho == OP_WR && hd[0]) hd = 16'h0FFF;
            step("R2 R3 R4 R5 R6 R8 R9 random", ho, ha, hd, co, ca, cd);
        end
        step("idle", OP_NONE, 3'd0, 16'h0, OP_NONE, 3'd0, 16'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule